// File: doc/BRIEF.md
# SD SPI Single-Block Data Mover

This block moves exactly one data block between on-chip byte streams and an SD memory card running in SPI mode, once the card has already accepted the read or write command. It does not drive SPI bits itself. It asks an external byte-wide SPI master for one byte exchange at a time: it supplies the byte to send and waits for the byte that came back.

For a read, the block keeps clocking idle bytes until the card sends its start token. It then hands each payload byte to a ready/valid output stream and drops the two trailing check bytes. For a write, it sends the start token, then the payload taken from a ready/valid input stream, then two filler bytes in place of the check value. It then decodes the card's data-response token and polls until the card releases its busy indication.

Chip select is driven low for the whole transfer. Every exit path raises chip select and clocks one trailing filler byte, then reports a result code with a one-cycle done pulse. The payload length is either a full sector or the short 16-byte register block. Both start-token hunting and busy polling are bounded by poll-count limits.

Top module: `sd_block_mover`

## Requirements
- R1: After reset `sd_cs_n` is 1 and `busy`, `done`, `spi_start` and `rd_valid` are 0.
- R2: At most one byte exchange is outstanding. After a `spi_start` pulse, the next one comes only after the cycle in which `spi_done` is seen.
- R3: Read (`go_write`=0): each exchange sends 0xFF. Received bytes are skipped until 0xFE arrives. The next BLK_BYTES bytes (REG_BYTES when `go_reg`=1) appear in order on `rd_data`, and two further exchanges are made whose bytes are discarded.
- R4: A byte on the read stream holds `rd_valid` with `rd_data` stable until `rd_ready`. No exchange is started while a byte waits there.
- R5: Write (`go_write`=1): the sent bytes are 0xFE, then the payload bytes in stream order, then 0xFF, 0xFF. `wr_ready` is high only when a payload exchange can be launched in that cycle.
- R6: After the two filler bytes, one 0xFF exchange fetches the response token and only its low five bits count. 0x05 means accepted. 0x0B ends with result 1 (check error). 0x0D ends with result 2 (write failure). Any other value ends with result 4 (bad token). A rejected token gets no busy polling.
- R7: After acceptance the block sends 0xFF while the received byte is 0x00. The first nonzero byte ends the transfer with result 0.
- R8: If HUNT_LIMIT received bytes all differ from 0xFE, or BUSY_LIMIT polled bytes are all 0x00, the transfer ends with result 3 (timeout). A match on the last allowed byte still succeeds.
- R9: On every exit path `sd_cs_n` rises before one final 0xFF exchange. Then `done` pulses for one cycle with `result` valid, `busy` falls in that same cycle, and `sd_cs_n` stays 1.
- R10: `go` is ignored while `busy` is 1.
- R11: `sd_cs_n` is 0 from the cycle after an accepted `go` through every exchange before the final one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start one block transfer (taken when not busy) |
| go_write | input | 1 | 1 = write block, 0 = read block |
| go_reg | input | 1 | 1 = REG_BYTES payload, 0 = BLK_BYTES payload |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| result | output | 3 | 0 ok, 1 check error, 2 write failure, 3 timeout, 4 bad token |
| sd_cs_n | output | 1 | Card chip select, active low |
| spi_start | output | 1 | Request one byte exchange (one-cycle pulse) |
| spi_tx | output | 8 | Byte to send, valid with `spi_start` |
| spi_done | input | 1 | Exchange finished, `spi_rx` valid |
| spi_rx | input | 8 | Byte received from the card |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Write payload byte taken this cycle if valid |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte available |
| rd_ready | input | 1 | Consumer takes read byte |

## Verification
A wrong state or byte count shows up at the SPI side within one exchange. A skipped or extra payload byte, or a missing filler byte, makes the next `spi_tx`/`sd_cs_n` pair differ from the bench's expected exchange list. A miscounted timeout moves the final chip-select rise by one exchange. A lost read byte or a stall-gating error shows up as a stream data mismatch or as an exchange launched while `rd_valid` is held. A decoding error in the response token shows only at `done`, through `result` and through whether busy polls were made, so the token cases each end a separate transfer.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_R_HUNT,
      ST_R_DATA,
      ST_R_CRC,
      ST_W_TOKEN,
      ST_W_DATA,
      ST_W_CRC,
      ST_W_RESP,
      ST_W_BUSY,
      ST_TAIL
   } sdm_state_e;

   typedef enum logic [2:0] {
      RES_OK        = 3'd0,
      RES_CRC_REJ   = 3'd1,
      RES_WR_REJ    = 3'd2,
      RES_TIMEOUT   = 3'd3,
      RES_BAD_TOKEN = 3'd4
   } sdm_result_e;

   localparam logic [7:0] BYTE_START = 8'hFE;
   localparam logic [7:0] BYTE_FILL  = 8'hFF;
   localparam logic [4:0] TOK_ACCEPT = 5'h05;
   localparam logic [4:0] TOK_CRC    = 5'h0B;
   localparam logic [4:0] TOK_WRITE  = 5'h0D;

endpackage

// File: rtl/sdm_poll_timer.sv
module sdm_poll_timer #(
   parameter int LIMIT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic last
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("sdm_poll_timer: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_single
      assign last = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(LIMIT);
      logic [CW-1:0] polls_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      polls_q <= '0;
         else if (clr)    polls_q <= '0;
         else if (tick)   polls_q <= polls_q + 1'b1;
      end

      assign last = (polls_q == CW'(LIMIT - 1));
   end

endmodule

// File: rtl/sdm_token_class.sv
module sdm_token_class
   import sdm_pkg::*;
(
   input  logic [4:0]  tok_low,
   output logic        accept,
   output sdm_result_e verdict
);

   always_comb begin
      accept = (tok_low == TOK_ACCEPT);
      unique case (tok_low)
         TOK_ACCEPT: verdict = RES_OK;
         TOK_CRC:    verdict = RES_CRC_REJ;
         TOK_WRITE:  verdict = RES_WR_REJ;
         default:    verdict = RES_BAD_TOKEN;
      endcase
   end

endmodule

// File: rtl/sd_block_mover.sv
module sd_block_mover
   import sdm_pkg::*;
#(
   parameter int BLK_BYTES  = 512,
   parameter int REG_BYTES  = 16,
   parameter int HUNT_LIMIT = 4096,
   parameter int BUSY_LIMIT = 65536
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       go_write,
   input  logic       go_reg,
   output logic       busy,
   output logic       done,
   output logic [2:0] result,
   output logic       sd_cs_n,
   output logic       spi_start,
   output logic [7:0] spi_tx,
   input  logic       spi_done,
   input  logic [7:0] spi_rx,
   input  logic [7:0] wr_data,
   input  logic       wr_valid,
   output logic       wr_ready,
   output logic [7:0] rd_data,
   output logic       rd_valid,
   input  logic       rd_ready
);

   localparam int CNT_W = $clog2(BLK_BYTES + 1);

   if (REG_BYTES < 1 || REG_BYTES > BLK_BYTES) begin : g_bad_len
      $error("sd_block_mover: need 1 <= REG_BYTES <= BLK_BYTES");
   end

   sdm_state_e       state_q;
   logic [CNT_W-1:0] cnt_q, len_q;
   logic             pend_q, start_q, cs_n_q, rd_vld_q, done_q;
   logic [7:0]       tx_q, rd_data_q;
   sdm_result_e      res_q;

   logic             want_issue, launch, rx_event;
   logic [7:0]       launch_tx;
   logic             hunt_last, busy_last, tok_accept;
   sdm_result_e      tok_verdict;
   logic             last_pay, crc_second;

   assign rx_event   = spi_done && pend_q;
   assign last_pay   = (cnt_q == len_q - CNT_W'(1));
   assign crc_second = (cnt_q == CNT_W'(1));

   sdm_poll_timer #(.LIMIT(HUNT_LIMIT)) i_hunt_timer (
      .clk(clk), .rst_n(rst_n),
      .clr (state_q != ST_R_HUNT),
      .tick(rx_event && state_q == ST_R_HUNT),
      .last(hunt_last)
   );

   sdm_poll_timer #(.LIMIT(BUSY_LIMIT)) i_busy_timer (
      .clk(clk), .rst_n(rst_n),
      .clr (state_q != ST_W_BUSY),
      .tick(rx_event && state_q == ST_W_BUSY),
      .last(busy_last)
   );

   sdm_token_class i_token_class (
      .tok_low(spi_rx[4:0]),
      .accept (tok_accept),
      .verdict(tok_verdict)
   );

   always_comb begin
      unique case (state_q)
         ST_IDLE:   want_issue = 1'b0;
         ST_W_DATA: want_issue = wr_valid;
         default:   want_issue = 1'b1;
      endcase
      unique case (state_q)
         ST_W_TOKEN: launch_tx = BYTE_START;
         ST_W_DATA:  launch_tx = wr_data;
         default:    launch_tx = BYTE_FILL;
      endcase
   end

   assign launch   = !pend_q && !rd_vld_q && want_issue;
   assign wr_ready = (state_q == ST_W_DATA) && !pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         len_q     <= '0;
         pend_q    <= 1'b0;
         start_q   <= 1'b0;
         tx_q      <= BYTE_FILL;
         cs_n_q    <= 1'b1;
         rd_vld_q  <= 1'b0;
         rd_data_q <= '0;
         done_q    <= 1'b0;
         res_q     <= RES_OK;
      end else begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         if (launch) begin
            start_q <= 1'b1;
            tx_q    <= launch_tx;
            pend_q  <= 1'b1;
         end
         if (rd_vld_q && rd_ready) rd_vld_q <= 1'b0;

         if (state_q == ST_IDLE) begin
            if (go) begin
               cs_n_q  <= 1'b0;
               cnt_q   <= '0;
               len_q   <= go_reg ? CNT_W'(REG_BYTES) : CNT_W'(BLK_BYTES);
               res_q   <= RES_OK;
               state_q <= go_write ? ST_W_TOKEN : ST_R_HUNT;
            end
         end else if (rx_event) begin
            pend_q <= 1'b0;
            unique case (state_q)
               ST_R_HUNT: begin
                  if (spi_rx == BYTE_START) begin
                     state_q <= ST_R_DATA;
                     cnt_q   <= '0;
                  end else if (hunt_last) begin
                     res_q   <= RES_TIMEOUT;
                     state_q <= ST_TAIL;
                     cs_n_q  <= 1'b1;
                  end
               end
               ST_R_DATA: begin
                  rd_data_q <= spi_rx;
                  rd_vld_q  <= 1'b1;
                  if (last_pay) begin
                     state_q <= ST_R_CRC;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_R_CRC: begin
                  if (crc_second) begin
                     state_q <= ST_TAIL;
                     cs_n_q  <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_W_TOKEN: begin
                  state_q <= ST_W_DATA;
                  cnt_q   <= '0;
               end
               ST_W_DATA: begin
                  if (last_pay) begin
                     state_q <= ST_W_CRC;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               ST_W_CRC: begin
                  if (crc_second) state_q <= ST_W_RESP;
                  else            cnt_q   <= cnt_q + 1'b1;
               end
               ST_W_RESP: begin
                  if (tok_accept) begin
                     state_q <= ST_W_BUSY;
                  end else begin
                     res_q   <= tok_verdict;
                     state_q <= ST_TAIL;
                     cs_n_q  <= 1'b1;
                  end
               end
               ST_W_BUSY: begin
                  if (spi_rx != 8'h00) begin
                     state_q <= ST_TAIL;
                     cs_n_q  <= 1'b1;
                  end else if (busy_last) begin
                     res_q   <= RES_TIMEOUT;
                     state_q <= ST_TAIL;
                     cs_n_q  <= 1'b1;
                  end
               end
               ST_TAIL: begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign result    = res_q;
   assign sd_cs_n   = cs_n_q;
   assign spi_start = start_q;
   assign spi_tx    = tx_q;
   assign rd_data   = rd_data_q;
   assign rd_valid  = rd_vld_q;

endmodule

// File: rtl/sd_block_mover_chk.sv
module sd_block_mover_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       go,
   input logic       busy,
   input logic       done,
   input logic [2:0] result,
   input logic       sd_cs_n,
   input logic       spi_start,
   input logic       spi_done,
   input logic       wr_ready,
   input logic [7:0] rd_data,
   input logic       rd_valid,
   input logic       rd_ready
);

   logic open_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         open_q <= 1'b0;
      else if (spi_start) open_q <= 1'b1;
      else if (spi_done)  open_q <= 1'b0;
   end

   AST_SINGLE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      spi_start |-> !open_q);                                              // R2
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));              // R4
   AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !spi_start);                                            // R4
   AST_WR_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> !spi_start && !open_q);                                 // R5
   AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> result <= 3'd4);                                            // R6
   AST_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sd_cs_n);                                                  // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                     // R9
   AST_DONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> sd_cs_n && !busy && !open_q);                               // R9
   AST_GO_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      go && !busy |=> busy && !sd_cs_n);                                   // R11

endmodule

bind sd_block_mover sd_block_mover_chk i_chk (.*);

// File: tb/test_sd_block_mover.sv
`timescale 1ns/1ps
module test_sd_block_mover;

   localparam int BLK  = 512;
   localparam int REG  = 16;
   localparam int HUNT = 20;
   localparam int BUSY = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       go = 1'b0, go_write = 1'b0, go_reg = 1'b0;
   logic       busy, done, sd_cs_n, spi_start, wr_ready, rd_valid;
   logic [2:0] result;
   logic [7:0] spi_tx, rd_data;
   logic       spi_done = 1'b0;
   logic [7:0] spi_rx = 8'hFF;
   logic [7:0] wr_data = 8'h00;
   logic       wr_valid = 1'b0;
   logic       rd_ready = 1'b0;

   sd_block_mover #(.BLK_BYTES(BLK), .REG_BYTES(REG),
                    .HUNT_LIMIT(HUNT), .BUSY_LIMIT(BUSY)) i_sd_block_mover (
      .clk(clk), .rst_n(rst_n), .go(go), .go_write(go_write), .go_reg(go_reg),
      .busy(busy), .done(done), .result(result), .sd_cs_n(sd_cs_n),
      .spi_start(spi_start), .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx),
      .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
   );

   always #2.5 clk = ~clk;

   int n_checks = 0, n_errs = 0;
   int cyc = 0, n_done = 0, last_res = 0;
   logic [8:0] exp_q[$];
   logic [7:0] rx_q[$];
   logic [7:0] pay_q[$];
   bit   pend = 0, wr_mode = 0;
   int   lat_left = 0, lat = 1, stall = 1;
   logic [7:0] pend_rx = 8'hFF;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      bit was_pend;
      @(negedge clk);
      cyc++;
      was_pend = pend;
      spi_done = 1'b0;
      if (pend) begin
         if (lat_left <= 1) begin
            spi_done = 1'b1;
            spi_rx   = pend_rx;
            pend     = 0;
         end else begin
            lat_left--;
         end
      end
      if (spi_start) begin
         chk(!was_pend, "R2", "exchange started while one open", 1, 0);
         if (exp_q.size() == 0) begin
            chk(0, "R9", "unexpected exchange", {sd_cs_n, spi_tx}, 0);
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk({sd_cs_n, spi_tx} == e, e[8] ? "R9" : "R11",
                "cs_n/tx of exchange", {sd_cs_n, spi_tx}, e);
         end
         pend_rx  = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hFF;
         pend     = 1;
         lat_left = lat;
      end
      if (wr_mode) begin
         rd_ready = 1'b1;
         if (rd_valid) chk(0, "R5", "read byte during write", 1, 0);
         if (pay_q.size() > 0) begin
            wr_valid = (stall <= 1) || (cyc % stall == 0);
            wr_data  = pay_q[0];
            if (wr_valid && wr_ready) void'(pay_q.pop_front());
         end else begin
            wr_valid = 1'b0;
         end
      end else begin
         wr_valid = 1'b0;
         rd_ready = (stall <= 1) || (cyc % stall == 0);
         if (rd_valid) begin
            chk(!spi_start, "R4", "exchange while read byte held", 1, 0);
            if (rd_ready) begin
               if (pay_q.size() == 0) chk(0, "R3", "extra read byte", rd_data, 0);
               else begin
                  logic [7:0] b;
                  b = pay_q.pop_front();
                  chk(rd_data == b, "R3", "read payload byte", rd_data, b);
               end
            end
         end
      end
      if (done) begin
         n_done++;
         last_res = int'(result);
      end
   endtask

   function automatic logic [7:0] pbyte(input int i, input int seed);
      return 8'(i * 37 + seed);
   endfunction

   task automatic plan_read(input int n, input int fill, input bit found, input int seed);
      for (int i = 0; i < fill; i++) begin
         exp_q.push_back({1'b0, 8'hFF});
         rx_q.push_back((i % 2) ? 8'hFF : 8'h7E);
      end
      if (found) begin
         exp_q.push_back({1'b0, 8'hFF});
         rx_q.push_back(8'hFE);
         for (int i = 0; i < n; i++) begin
            exp_q.push_back({1'b0, 8'hFF});
            rx_q.push_back(pbyte(i, seed));
            pay_q.push_back(pbyte(i, seed));
         end
         for (int i = 0; i < 2; i++) begin
            exp_q.push_back({1'b0, 8'hFF});
            rx_q.push_back(8'hFE);
         end
      end
      exp_q.push_back({1'b1, 8'hFF});
      rx_q.push_back(8'hFF);
   endtask

   task automatic plan_write(input int n, input logic [7:0] tok, input int zeros,
                             input bit finish, input int seed);
      exp_q.push_back({1'b0, 8'hFE});
      rx_q.push_back(8'hFF);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back({1'b0, pbyte(i, seed)});
         rx_q.push_back(8'hFF);
         pay_q.push_back(pbyte(i, seed));
      end
      for (int i = 0; i < 2; i++) begin
         exp_q.push_back({1'b0, 8'hFF});
         rx_q.push_back(8'hFF);
      end
      exp_q.push_back({1'b0, 8'hFF});
      rx_q.push_back(tok);
      if (tok[4:0] == 5'h05) begin
         for (int i = 0; i < zeros; i++) begin
            exp_q.push_back({1'b0, 8'hFF});
            rx_q.push_back(8'h00);
         end
         if (finish) begin
            exp_q.push_back({1'b0, 8'hFF});
            rx_q.push_back(8'h80);
         end
      end
      exp_q.push_back({1'b1, 8'hFF});
      rx_q.push_back(8'hFF);
   endtask

   task automatic run(input bit wr, input bit rg, input int res_exp, input int l,
                      input int st, input bit inject, input string req);
      int k;
      wr_mode  = wr;
      lat      = l;
      stall    = st;
      n_done   = 0;
      go_write = wr;
      go_reg   = rg;
      go       = 1'b1;
      step();
      go       = 1'b0;
      k = 0;
      while (n_done == 0 && k < 20000) begin
         if (inject && k == 8) begin
            go = 1'b1;
            go_write = ~wr;
            go_reg = ~rg;
            step();
            go = 1'b0;
            go_write = wr;
            go_reg = rg;
            chk(busy == 1'b1, "R10", "busy kept after ignored go", busy, 1);
         end else begin
            step();
         end
         k++;
      end
      chk(n_done == 1, req, "done seen", n_done, 1);
      chk(busy == 1'b0 && sd_cs_n == 1'b1, "R9", "idle frame at done",
          {busy, sd_cs_n}, 1);
      chk(last_res == res_exp, req, "result code", last_res, res_exp);
      for (int i = 0; i < 4; i++) step();
      chk(n_done == 1, "R9", "single done pulse", n_done, 1);
      chk(exp_q.size() == 0, req, "exchanges left over", exp_q.size(), 0);
      chk(pay_q.size() == 0, req, "payload bytes left over", pay_q.size(), 0);
      exp_q.delete();
      rx_q.delete();
      pay_q.delete();
   endtask

   initial begin
      #(190000 * 5);
      n_errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

   initial begin
      repeat (3) step();
      chk(sd_cs_n == 1'b1, "R1", "cs_n in reset", sd_cs_n, 1);
      chk({busy, done, spi_start, rd_valid} == 4'b0, "R1", "outputs in reset",
          {busy, done, spi_start, rd_valid}, 0);
      rst_n = 1'b1;
      step();
      chk({busy, done, spi_start, sd_cs_n} == 4'b0001, "R1", "state after reset",
          {busy, done, spi_start, sd_cs_n}, 1);

      // R3: full sector read, three idle bytes before the start token
      plan_read(BLK, 3, 1, 5);
      run(0, 0, 0, 1, 1, 0, "R3");
      // R4 + R10: short register read, slow consumer, stray go mid transfer
      plan_read(REG, 0, 1, 91);
      run(0, 1, 0, 3, 3, 1, "R4");
      // R5 + R7: sector write, stalled source, accepted then four busy bytes
      plan_write(BLK, 8'hE5, 4, 1, 17);
      run(1, 0, 0, 2, 2, 0, "R7");
      // R6: rejection tokens
      plan_write(REG, 8'hEB, 0, 0, 3);
      run(1, 1, 1, 1, 1, 0, "R6");
      plan_write(REG, 8'h0D, 0, 0, 4);
      run(1, 1, 2, 1, 1, 0, "R6");
      plan_write(REG, 8'h03, 0, 0, 6);
      run(1, 1, 4, 2, 1, 0, "R6");
      // R8: start-token hunt limit and its boundary
      plan_read(0, HUNT, 0, 0);
      run(0, 1, 3, 1, 1, 0, "R8");
      plan_read(REG, HUNT - 1, 1, 33);
      run(0, 1, 0, 1, 1, 0, "R8");
      // R8: busy limit and its boundary
      plan_write(REG, 8'h05, BUSY, 0, 8);
      run(1, 1, 3, 1, 1, 0, "R8");
      plan_write(REG, 8'h05, BUSY - 1, 1, 9);
      run(1, 1, 0, 1, 2, 0, "R8");

      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

endmodule